// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send and Auto Ready-to-Send

This block turns characters of five to eight data bits into an asynchronous serial frame on a single line. All timing is paced by a clock enable that pulses sixteen times per bit. A one-character holding register takes each write and shows whether it can accept another character. A shift engine sends a low start bit, the data bits least significant first, an optional parity bit, and then a high stop period. The stop period is set in sixteenths of a bit. Two characters written in a row go out back to back, with no idle time between them.

Two flow-control features are built in. With clear-to-send gating on, a character does not begin until the clear-to-send input is asserted. That input is checked only when a character is about to start. With automatic ready-to-send on, software raises the ready-to-send output through a set strobe. The block lowers it by itself one bit time after the last stop period, once nothing is left to send. If both features are enabled together, clear-to-send gating takes precedence and the automatic lowering is suppressed.

Character length, parity mode and stop code are captured when each character starts. A change to them during a frame applies to the next character.

Top module: `uart_tx_fc`

## Requirements
- R1: A write strobe drives `thr_empty` low on the next cycle. The flag returns high in the cycle after the character moves from the holding register into the shift engine.
- R2: The idle line is high. A frame is a low start bit, then N data bits LSB first, each lasting 16 ticks, where N = `char_len` + 5 (code 0 = 5 bits up to code 3 = 8 bits).
- R3: `par_mode` 2'b01 appends an even-parity bit and 2'b10 appends an odd-parity bit, each lasting 16 ticks and computed over the N data bits only. Codes 2'b00 and 2'b11 append no parity bit.
- R4: For characters of 6 to 8 bits, the stop period lasts `stop_code`+9 ticks when `stop_code[3]` is 0, and `stop_code`+17 ticks when it is 1.
- R5: For 5-bit characters, the stop period lasts `stop_code`+17 ticks for every code.
- R6: A character already waiting in the holding register starts on the tick that ends the previous stop period. The frame-to-frame period is therefore exactly 16·(1+N+P)+stop ticks, where P is 1 with parity and 0 without.
- R7: With `cts_en`=1 and `cts_i`=0, a waiting character does not start: `txd` stays high and `thr_empty` stays low.
- R8: A change on `cts_i` after a character has started does not alter that character.
- R9: A pulse on `rts_set` makes `rts_o` high on the next cycle.
- R10: With `rts_en`=1 and `cts_en`=0, `rts_o` falls exactly 16 ticks after the final stop period ends, provided the holding register is still empty.
- R11: A write during that 16-tick wait cancels the pending fall. `rts_o` then stays high until 16 ticks after the new character drains.
- R12: When `cts_en` and `rts_en` are both 1, or when `rts_en` is 0, `rts_o` is never lowered automatically.
- R13: Frame timing advances only on cycles with `tick16` high. While `tick16` is low, `txd` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | Clock enable, sixteen pulses per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | MAX_BITS | Character to send; unused upper bits are ignored |
| thr_empty | output | 1 | High when the holding register can take a character |
| char_len | input | 2 | Data bits per character minus five |
| par_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| stop_code | input | 4 | Stop-period length code |
| cts_en | input | 1 | Enables clear-to-send gating of character starts |
| rts_en | input | 1 | Enables automatic lowering of ready-to-send |
| cts_i | input | 1 | Clear-to-send, high = send permitted |
| rts_set | input | 1 | Strobe that raises ready-to-send |
| rts_o | output | 1 | Ready-to-send output |
| txd | output | 1 | Serial data line, idle high |

## Verification
A slipped tick counter or bit index in the shift engine moves an edge on `txd` inside the first bit time after the fault, so the bench samples every bit at its centre. A wrong stop decode or a lost holding-register flag shows only at frame boundaries. The bench therefore measures the exact tick on which the next start edge falls, which catches an error of a single sixteenth one frame later. A wrong drain timer or arm flag shows as `rts_o` falling one tick early or late, or not falling at all. It is checked on both sides of the expected tick and when a late write cancels the fall.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Ticks per bit time; stop lengths are expressed in these units.
  localparam int TICKS_PER_BIT = 16;
  // Counter wide enough for the longest stop period (32 ticks).
  localparam int TICK_CNT_W    = 6;
  localparam int RTS_CNT_W     = $clog2(TICKS_PER_BIT);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_OFF     = 2'b00,
    PAR_EVEN    = 2'b01,
    PAR_ODD     = 2'b10,
    PAR_OFF_ALT = 2'b11
  } par_mode_e;

endpackage

// File: rtl/uart_tx_stop_decode.sv
module uart_tx_stop_decode
  import uart_tx_pkg::*;
(
  input  logic [3:0]            code_i,
  input  logic                  short_char_i,
  output logic [TICK_CNT_W-1:0] last_tick_o
);

  localparam int PAD_W = TICK_CNT_W - 4;

  logic [TICK_CNT_W-1:0] code_ext;

  assign code_ext = {{PAD_W{1'b0}}, code_i};

  // Output is the index of the final stop tick (length minus one).
  always_comb begin
    if (short_char_i || code_i[3]) begin
      last_tick_o = code_ext + TICK_CNT_W'(16);
    end else begin
      last_tick_o = code_ext + TICK_CNT_W'(8);
    end
  end

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [1:0]          len_sel_i,
  input  logic [1:0]          mode_i,
  output logic                par_en_o,
  output logic                par_bit_o
);

  localparam int MIN_BITS = 5;

  logic [MAX_BITS-1:0] mask;
  logic                odd_sum;

  generate
    for (genvar gi = 0; gi < MAX_BITS; gi++) begin : g_mask
      assign mask[gi] = (gi < MIN_BITS) ? 1'b1 :
                        (gi < (MIN_BITS + int'(len_sel_i)));
    end
  endgenerate

  assign odd_sum   = ^(data_i & mask);
  assign par_en_o  = (par_mode_e'(mode_i) == PAR_EVEN) ||
                     (par_mode_e'(mode_i) == PAR_ODD);
  assign par_bit_o = odd_sum ^ (par_mode_e'(mode_i) == PAR_ODD);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic [MAX_BITS-1:0]   wr_data_i,
  input  logic [1:0]            len_sel_i,
  input  logic                  cts_ok_i,
  input  logic                  par_en_i,
  input  logic                  par_bit_i,
  input  logic [TICK_CNT_W-1:0] stop_last_i,
  output logic [MAX_BITS-1:0]   hold_data_o,
  output logic                  txd_o,
  output logic                  thr_empty_o,
  output logic                  idle_o,
  output logic                  frame_done_o
);

  localparam int IDX_W = $clog2(MAX_BITS);
  localparam logic [TICK_CNT_W-1:0] BIT_LAST = TICK_CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0]      MIN_LAST = IDX_W'(4);

  tx_state_e             state_q, state_d;
  logic [TICK_CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [IDX_W-1:0]      last_q, last_d;
  logic [MAX_BITS-1:0]   shf_q, shf_d;
  logic [MAX_BITS-1:0]   hold_q, hold_d;
  logic                  full_q, full_d;
  logic                  par_en_q, par_en_d;
  logic                  par_bit_q, par_bit_d;
  logic [TICK_CNT_W-1:0] stop_last_q, stop_last_d;
  logic                  txd_q, txd_d;
  logic                  load;
  logic                  done;
  logic                  start_ok;

  assign start_ok = full_q && cts_ok_i;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    last_d      = last_q;
    shf_d       = shf_q;
    hold_d      = hold_q;
    par_en_d    = par_en_q;
    par_bit_d   = par_bit_q;
    stop_last_d = stop_last_q;
    load        = 1'b0;
    done        = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (tick_i && start_ok) load = 1'b1;
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == BIT_LAST) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            idx_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            if (idx_q == last_q) begin
              state_d = par_en_q ? ST_PAR : ST_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (tick_i) begin
          if (cnt_q == BIT_LAST) begin
            state_d = ST_STOP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (cnt_q == stop_last_q) begin
            if (start_ok) begin
              load = 1'b1;
            end else begin
              state_d = ST_IDLE;
              cnt_d   = '0;
              done    = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase

    // Capture character and its framing on start
    if (load) begin
      state_d     = ST_START;
      cnt_d       = '0;
      idx_d       = '0;
      shf_d       = hold_q;
      last_d      = IDX_W'(len_sel_i) + MIN_LAST;
      par_en_d    = par_en_i;
      par_bit_d   = par_bit_i;
      stop_last_d = stop_last_i;
    end

    full_d = load ? 1'b0 : full_q;
    if (wr_en_i) begin
      full_d = 1'b1;
      hold_d = wr_data_i;
    end

    unique case (state_d)
      ST_START: txd_d = 1'b0;
      ST_DATA:  txd_d = shf_d[idx_d];
      ST_PAR:   txd_d = par_bit_d;
      default:  txd_d = 1'b1;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      last_q      <= '0;
      shf_q       <= '0;
      hold_q      <= '0;
      full_q      <= 1'b0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_last_q <= '0;
      txd_q       <= 1'b1;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      idx_q       <= idx_d;
      last_q      <= last_d;
      shf_q       <= shf_d;
      hold_q      <= hold_d;
      full_q      <= full_d;
      par_en_q    <= par_en_d;
      par_bit_q   <= par_bit_d;
      stop_last_q <= stop_last_d;
      txd_q       <= txd_d;
    end
  end

  assign hold_data_o  = hold_q;
  assign txd_o        = txd_q;
  assign thr_empty_o  = !full_q;
  assign idle_o       = (state_q == ST_IDLE);
  assign frame_done_o = done;

endmodule

// File: rtl/uart_tx_rts_ctrl.sv
module uart_tx_rts_ctrl
  import uart_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic set_i,
  input  logic auto_en_i,
  input  logic frame_done_i,
  input  logic wr_en_i,
  input  logic drained_i,
  output logic rts_o
);

  localparam logic [RTS_CNT_W-1:0] WAIT_LAST = RTS_CNT_W'(TICKS_PER_BIT - 1);

  logic                 rts_q, rts_d;
  logic                 armed_q, armed_d;
  logic [RTS_CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    rts_d   = rts_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;

    if (frame_done_i && auto_en_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q) begin
      if (wr_en_i || !drained_i || !auto_en_i) begin
        armed_d = 1'b0;
      end else if (tick_i) begin
        if (cnt_q == WAIT_LAST) begin
          armed_d = 1'b0;
          rts_d   = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end

    if (set_i) rts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      rts_q   <= rts_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rts_o = rts_q;

endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc
  import uart_tx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  output logic                thr_empty,
  input  logic [1:0]          char_len,
  input  logic [1:0]          par_mode,
  input  logic [3:0]          stop_code,
  input  logic                cts_en,
  input  logic                rts_en,
  input  logic                cts_i,
  input  logic                rts_set,
  output logic                rts_o,
  output logic                txd
);

  logic [1:0]            rst_pipe;
  logic                  rst_n_s;
  logic [TICK_CNT_W-1:0] stop_last;
  logic [MAX_BITS-1:0]   hold_data;
  logic                  par_en;
  logic                  par_bit;
  logic                  sh_idle;
  logic                  frame_done;
  logic                  cts_ok;
  logic                  rts_auto;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign cts_ok   = !cts_en || cts_i;
  // Clear-to-send gating takes precedence over automatic RTS
  assign rts_auto = rts_en && !cts_en;

  uart_tx_stop_decode u_stop (
    .code_i       (stop_code),
    .short_char_i (char_len == 2'b00),
    .last_tick_o  (stop_last)
  );

  uart_tx_parity #(.MAX_BITS(MAX_BITS)) u_par (
    .data_i    (hold_data),
    .len_sel_i (char_len),
    .mode_i    (par_mode),
    .par_en_o  (par_en),
    .par_bit_o (par_bit)
  );

  uart_tx_shifter #(.MAX_BITS(MAX_BITS)) u_shf (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .tick_i       (tick16),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .len_sel_i    (char_len),
    .cts_ok_i     (cts_ok),
    .par_en_i     (par_en),
    .par_bit_i    (par_bit),
    .stop_last_i  (stop_last),
    .hold_data_o  (hold_data),
    .txd_o        (txd),
    .thr_empty_o  (thr_empty),
    .idle_o       (sh_idle),
    .frame_done_o (frame_done)
  );

  uart_tx_rts_ctrl u_rts (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .tick_i       (tick16),
    .set_i        (rts_set),
    .auto_en_i    (rts_auto),
    .frame_done_i (frame_done),
    .wr_en_i      (wr_en),
    .drained_i    (sh_idle && thr_empty),
    .rts_o        (rts_o)
  );

endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk
  import uart_tx_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n_s,
  input logic                  tick16,
  input logic                  wr_en,
  input logic                  thr_empty,
  input logic                  cts_en,
  input logic                  cts_i,
  input logic                  rts_en,
  input logic                  rts_set,
  input logic                  rts_o,
  input logic                  txd,
  input logic                  sh_idle,
  input logic [TICK_CNT_W-1:0] stop_last
);

  p_wr_marks_full_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en |=> !thr_empty);

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    sh_idle |-> txd);

  // Stop period covers R4 and R5: 9 to 32 ticks
  p_stop_window_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stop_last >= TICK_CNT_W'(8)) && (stop_last <= TICK_CNT_W'(31)));

  p_cts_holds_start_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick16 && cts_en && !cts_i && sh_idle) |=> sh_idle);

  p_rts_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    rts_set |=> rts_o);

  p_rts_kept_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rts_o && !(rts_en && !cts_en)) |=> rts_o);

  p_tick_paces_r13: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tick16 |=> $stable(txd));

endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .tick16    (tick16),
  .wr_en     (wr_en),
  .thr_empty (thr_empty),
  .cts_en    (cts_en),
  .cts_i     (cts_i),
  .rts_en    (rts_en),
  .rts_set   (rts_set),
  .rts_o     (rts_o),
  .txd       (txd),
  .sh_idle   (sh_idle),
  .stop_last (stop_last)
);

// File: tb/sim_uart_tx_fc.sv
module sim_uart_tx_fc;

  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       thr_empty;
  logic [1:0] char_len;
  logic [1:0] par_mode;
  logic [3:0] stop_code;
  logic       cts_en;
  logic       rts_en;
  logic       cts_i;
  logic       rts_set;
  logic       rts_o;
  logic       txd;

  int n_chk  = 0;
  int n_fail = 0;

  uart_tx_fc #(.MAX_BITS(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .thr_empty (thr_empty),
    .char_len  (char_len),
    .par_mode  (par_mode),
    .stop_code (stop_code),
    .cts_en    (cts_en),
    .rts_en    (rts_en),
    .cts_i     (cts_i),
    .rts_set   (rts_set),
    .rts_o     (rts_o),
    .txd       (txd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stop_ticks(input int len, input int code);
    if (len == 5 || code >= 8) return code + 17;
    return code + 9;
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input int len, input logic odd);
    logic acc = 1'b0;
    for (int i = 0; i < len; i++) acc ^= d[i];
    return acc ^ odd;
  endfunction

  task automatic set_cfg(input int len, input int par, input int code);
    char_len  = 2'(len - 5);
    par_mode  = 2'(par);
    stop_code = 4'(code);
  endtask

  task automatic write_char(input logic [7:0] d, input bit check_flag);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (check_flag) begin
      chk_eq("R1 empty low after write", int'(thr_empty), 0);
      @(negedge clk);
      chk_eq("R1 empty high after load", int'(thr_empty), 1);
    end
  endtask

  task automatic wait_start(output bit seen);
    int w = 0;
    while (txd === 1'b1 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    seen = (txd === 1'b0);
  endtask

  // Entered at the centre of the start bit
  task automatic rx_from_center(input int len, input bit has_par,
                                output logic [7:0] d, output logic pb,
                                output logic st, output logic sp);
    d  = '0;
    pb = 1'b0;
    st = txd;
    for (int k = 0; k < len; k++) begin
      repeat (16) @(negedge clk);
      d[k] = txd;
    end
    if (has_par) begin
      repeat (16) @(negedge clk);
      pb = txd;
    end
    repeat (16) @(negedge clk);
    sp = txd;
  endtask

  task automatic rx_frame(input int len, input bit has_par,
                          output logic [7:0] d, output logic pb,
                          output logic st, output logic sp);
    repeat (8) @(negedge clk);
    rx_from_center(len, has_par, d, pb, st, sp);
  endtask

  task automatic pulse_rts_set();
    @(negedge clk);
    rts_set = 1'b1;
    @(negedge clk);
    rts_set = 1'b0;
    chk_eq("R9 rts high after set", int'(rts_o), 1);
  endtask

  task automatic t_reset();
    chk_eq("R2 idle line high after reset", int'(txd), 1);
    chk_eq("R1 empty after reset", int'(thr_empty), 1);
    chk_eq("R9 rts low after reset", int'(rts_o), 0);
  endtask

  task automatic send_one(input logic [7:0] c, input int len, input int par);
    bit seen;
    logic [7:0] d;
    logic pb, st, sp;
    logic [7:0] mask;
    set_cfg(len, par, 7);
    write_char(c, 1'b1);
    wait_start(seen);
    chk_eq("R2 start seen", int'(seen), 1);
    rx_frame(len, (par == 1 || par == 2), d, pb, st, sp);
    mask = 8'((1 << len) - 1);
    chk_eq("R2 start bit low", int'(st), 0);
    chk_eq("R2 data LSB first", int'(d), int'(c & mask));
    if (par == 1 || par == 2)
      chk_eq("R3 parity bit", int'(pb), int'(exp_par(c, len, par == 2)));
    chk_eq("R2 stop high", int'(sp), 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_formats();
    send_one(8'hA5, 8, 0);
    send_one(8'h53, 7, 1);
    send_one(8'h2C, 6, 2);
    send_one(8'hF3, 5, 1);
    send_one(8'h80, 8, 2);
    send_one(8'h61, 8, 3);
  endtask

  task automatic stop_case(input int len, input int code, input string req);
    bit seen;
    int L;
    set_cfg(len, 0, code);
    L = 16 * (1 + len) + stop_ticks(len, code);
    write_char(8'h6B, 1'b1);
    wait_start(seen);
    chk_eq("R6 first start seen", int'(seen), 1);
    write_char(8'h0F, 1'b0);
    repeat (L - 3) @(negedge clk);
    chk_eq({req, " stop still high on last tick"}, int'(txd), 1);
    @(negedge clk);
    chk_eq({"R6 ", req, " next start exactly after stop"}, int'(txd), 0);
    repeat (L + 30) @(negedge clk);
  endtask

  task automatic t_stop();
    stop_case(8, 0, "R4 code0");
    stop_case(8, 7, "R4 code7");
    stop_case(6, 8, "R4 code8");
    stop_case(7, 15, "R4 code15");
    stop_case(5, 0, "R5 code0");
    stop_case(5, 15, "R5 code15");
  endtask

  task automatic t_cts();
    bit seen;
    int highs = 0;
    logic [7:0] d;
    logic pb, st, sp;
    set_cfg(8, 0, 7);
    cts_en = 1'b1;
    cts_i  = 1'b0;
    write_char(8'h3C, 1'b0);
    repeat (100) begin
      @(negedge clk);
      if (txd) highs++;
    end
    chk_eq("R7 line held high without CTS", highs, 100);
    chk_eq("R7 holding register kept", int'(thr_empty), 0);
    cts_i = 1'b1;
    wait_start(seen);
    chk_eq("R7 start after CTS asserts", int'(seen), 1);
    cts_i = 1'b0;
    rx_frame(8, 1'b0, d, pb, st, sp);
    chk_eq("R8 data unaffected by CTS drop", int'(d), 8'h3C);
    chk_eq("R8 stop unaffected by CTS drop", int'(sp), 1);
    cts_en = 1'b0;
    cts_i  = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_rts();
    bit seen;
    logic [7:0] d;
    logic pb, st, sp;
    set_cfg(8, 0, 7);
    rts_en = 1'b1;
    pulse_rts_set();
    write_char(8'h99, 1'b1);
    wait_start(seen);
    rx_frame(8, 1'b0, d, pb, st, sp);
    chk_eq("R10 rts high during frame", int'(rts_o), 1);
    repeat (23) @(negedge clk);
    chk_eq("R10 rts high one tick before drop", int'(rts_o), 1);
    @(negedge clk);
    chk_eq("R10 rts low one bit after drain", int'(rts_o), 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_cancel();
    bit seen;
    logic [7:0] d;
    logic pb, st, sp;
    set_cfg(8, 0, 7);
    rts_en = 1'b1;
    pulse_rts_set();
    write_char(8'h11, 1'b1);
    wait_start(seen);
    rx_frame(8, 1'b0, d, pb, st, sp);
    repeat (13) @(negedge clk);
    write_char(8'hE7, 1'b0);
    wait_start(seen);
    chk_eq("R11 second start seen", int'(seen), 1);
    rx_frame(8, 1'b0, d, pb, st, sp);
    chk_eq("R11 pending drop cancelled", int'(rts_o), 1);
    chk_eq("R11 second data", int'(d), 8'hE7);
    repeat (23) @(negedge clk);
    chk_eq("R11 rts high before rearmed drop", int'(rts_o), 1);
    @(negedge clk);
    chk_eq("R10 rts low after second drain", int'(rts_o), 0);
    rts_en = 1'b0;
  endtask

  task automatic t_both();
    bit seen;
    logic [7:0] d;
    logic pb, st, sp;
    set_cfg(8, 0, 7);
    rts_en = 1'b1;
    cts_en = 1'b1;
    cts_i  = 1'b1;
    pulse_rts_set();
    write_char(8'h5A, 1'b1);
    wait_start(seen);
    rx_frame(8, 1'b0, d, pb, st, sp);
    repeat (60) @(negedge clk);
    chk_eq("R12 rts kept when CTS gating also on", int'(rts_o), 1);
    cts_en = 1'b0;
    rts_en = 1'b0;
    repeat (60) @(negedge clk);
    chk_eq("R12 rts kept when auto RTS off", int'(rts_o), 1);
  endtask

  task automatic t_tick();
    bit seen;
    int moved = 0;
    logic [7:0] d;
    logic pb, st, sp;
    set_cfg(8, 1, 7);
    write_char(8'hC6, 1'b1);
    wait_start(seen);
    repeat (4) @(negedge clk);
    tick16 = 1'b0;
    repeat (50) begin
      @(negedge clk);
      if (txd !== 1'b0) moved++;
    end
    chk_eq("R13 line frozen without ticks", moved, 0);
    tick16 = 1'b1;
    repeat (4) @(negedge clk);
    rx_from_center(8, 1'b1, d, pb, st, sp);
    chk_eq("R13 start after pause", int'(st), 0);
    chk_eq("R13 data after pause", int'(d), 8'hC6);
    chk_eq("R3 even parity after pause", int'(pb), int'(exp_par(8'hC6, 8, 1'b0)));
    chk_eq("R13 stop after pause", int'(sp), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d cycles expected fewer", 150000);
    summary();
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    tick16  = 1'b1;
    wr_en   = 1'b0;
    wr_data = '0;
    cts_en  = 1'b0;
    rts_en  = 1'b0;
    cts_i   = 1'b1;
    rts_set = 1'b0;
    set_cfg(8, 0, 7);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_formats();
    t_stop();
    t_cts();
    t_rts();
    t_cancel();
    t_both();
    t_tick();
    summary();
    $finish;
  end

endmodule